// File: doc/BRIEF.md
# Return Address Stack with Interrupt Hold-Off

This block is the hardware stack that holds subroutine and interrupt return addresses for a small 8-bit microcontroller core. The core presents a return address and raises a push request when it executes a subroutine call. It raises a pop request on a return, and it takes the restored program counter from the block in that same cycle. The stack holds four entries. A call made on a full stack does not stall: it overwrites the oldest entry, and that entry is lost.

The block also stands between the interrupt controller and the core. A pulse on the unmasked interrupt request sets a pending latch. The block grants acknowledge only when the stack has room and the core is not pushing or popping in that cycle. In the acknowledge cycle the stack saves the presented address as the interrupt's return address. While the stack is full, the request stays pending. It is granted once a return has freed a level.

Top module: `retStack`

## Requirements
- R1: After reset, stackFull and irqAck are 0, and a pop returns address 0 with underflow high.
- R2: A pop on a non-empty stack drives popAddr, in the same cycle, with the most recently saved address that is still held. The stack is last-in first-out.
- R3: The stack holds four entries. stackFull is 1 exactly when four entries are held.
- R4: A push on a full stack drops the oldest entry and keeps stackFull at 1. The next four pops then return the four newest addresses, newest first, and a fifth pop underflows.
- R5: A pop on an empty stack drives popAddr to 0 and underflow to 1 in that cycle, and leaves the stack empty. underflow is 0 in every other cycle.
- R6: Push and pop in the same cycle on a non-empty stack return the current top on popAddr and replace it with pushAddr. The depth does not change. On an empty stack the same pair returns 0, raises underflow and saves pushAddr as the only entry.
- R7: A cycle with irqReq high sets a pending latch. irqAck is high exactly when the latch is set, the stack is not full, and neither pushReq nor popReq is high.
- R8: In a cycle with irqAck high, pushAddr is saved as a new entry and the pending latch clears. A request that arrives in that same cycle merges into the one being acknowledged.
- R9: While the stack is full a pending interrupt is not acknowledged. After a pop frees a level, irqAck rises in the next cycle that has no push or pop.
- R10: A synchronous active-high reset empties the stack and clears the pending latch, even when both are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pushReq | input | 1 | Save pushAddr (subroutine call) |
| pushAddr | input | ADDR_W | Return address to save |
| popReq | input | 1 | Restore the top entry (return) |
| popAddr | output | ADDR_W | Restored address, valid in the pop cycle, 0 on underflow |
| stackFull | output | 1 | Four entries held |
| underflow | output | 1 | Pop attempted on an empty stack |
| irqReq | input | 1 | Unmasked interrupt request pulse |
| irqAck | output | 1 | Interrupt acknowledge; pushAddr saved this cycle |

## Verification
Three kinds of wrong internal state show up at the ports in different ways. A wrong depth count shows up at once on stackFull or irqAck. A wrong pointer or a bad stored entry stays hidden until the next pop, and then shows up on popAddr in that pop's own cycle. A stale or lost pending latch shows up as an extra or missing irqAck in the first idle cycle with room on the stack. Random mixes of call, return and interrupt traffic are compared cycle by cycle against a bench model of a bounded queue. Directed runs cover the wrap on a full stack, replace on empty and full stacks, and the release of an interrupt held off while the stack is full.

// File: rtl/retStackPkg.sv
package retStackPkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic advance;   // bump pointer and write pushAddr at the new top
    logic retreat;   // drop pointer by one level
    logic replace;   // overwrite current top with pushAddr
    logic readOk;    // top entry is valid for popAddr
  } ctlStrobes_t;
endpackage

// File: rtl/retStackCtl.sv
module retStackCtl
  import retStackPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pushReq,
  input  logic        popReq,
  input  logic        irqReq,
  output logic        stackFull,
  output logic        underflow,
  output logic        irqAck,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count, nextCount;
  logic irqPend, isEmpty;

  assign stackFull = (count == FULL_CNT);
  assign isEmpty   = (count == '0);
  assign irqAck    = irqPend && !stackFull && !pushReq && !popReq;

  always_comb begin
    strobes   = '0;
    nextCount = count;
    underflow = 1'b0;
    if (irqAck) begin
      strobes.advance = 1'b1;
      nextCount = count + CNT_W'(1);
    end else if (pushReq && popReq) begin
      if (isEmpty) begin
        underflow = 1'b1;
        strobes.advance = 1'b1;
        nextCount = CNT_W'(1);
      end else begin
        strobes.replace = 1'b1;
        strobes.readOk  = 1'b1;
      end
    end else if (pushReq) begin
      strobes.advance = 1'b1;
      if (!stackFull) nextCount = count + CNT_W'(1);
    end else if (popReq) begin
      if (isEmpty) begin
        underflow = 1'b1;
      end else begin
        strobes.retreat = 1'b1;
        strobes.readOk  = 1'b1;
        nextCount = count - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      irqPend <= 1'b0;
    end else begin
      count   <= nextCount;
      irqPend <= irqAck ? 1'b0 : (irqPend || irqReq);
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  // R9
  ack_room_chk: assert property (@(posedge clk) disable iff (rst)
    irqAck |-> !stackFull);
  // R4
  full_call_chk: assert property (@(posedge clk) disable iff (rst)
    (stackFull && pushReq && !popReq) |=> stackFull);
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !pushReq) |=> (count == '0));
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irqPend && stackFull && !popReq) |=> irqPend);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irqAck |=> !irqPend && (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/retStackDp.sv
module retStackDp
  import retStackPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic [ADDR_W-1:0] popAddr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  topPtr, upPtr, downPtr;

  assign upPtr   = (topPtr == LAST) ? '0 : topPtr + PTR_W'(1);
  assign downPtr = (topPtr == '0) ? LAST : topPtr - PTR_W'(1);
  assign popAddr = strobes.readOk ? slots[topPtr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr <= LAST;
    end else if (strobes.advance) begin
      topPtr <= upPtr;
    end else if (strobes.retreat) begin
      topPtr <= downPtr;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst && ((strobes.advance && upPtr == PTR_W'(i)) ||
                     (strobes.replace && topPtr == PTR_W'(i))))
          slots[i] <= pushAddr;
      end
    end
  endgenerate

  // R6
  replace_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.replace |=> $stable(topPtr));
  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.advance, strobes.retreat, strobes.replace}));
endmodule

// File: rtl/retStack.sv
module retStack
  import retStackPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushReq,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              popReq,
  output logic [ADDR_W-1:0] popAddr,
  output logic              stackFull,
  output logic              underflow,
  input  logic              irqReq,
  output logic              irqAck
);
  ctlStrobes_t strobes;

  retStackCtl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst(rst), .pushReq(pushReq), .popReq(popReq),
    .irqReq(irqReq), .stackFull(stackFull), .underflow(underflow),
    .irqAck(irqAck), .strobes(strobes)
  );

  retStackDp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .pushAddr(pushAddr), .popAddr(popAddr)
  );

  // R5
  under_zero_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (popAddr == '0));
endmodule

// File: tb/retStack_tb.sv
module retStack_tb;
  localparam int AW = 13;
  localparam int DP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic pushReq = 0, popReq = 0, irqReq = 0;
  logic [AW-1:0] pushAddr = '0;
  logic [AW-1:0] popAddr;
  logic stackFull, underflow, irqAck;

  int nVec = 0, nBad = 0;
  logic [AW-1:0] model[$];
  bit pend = 0;

  always #4 clk = ~clk;

  retStack #(.ADDR_W(AW), .DEPTH(DP)) u_dut (
    .clk(clk), .rst(rst), .pushReq(pushReq), .pushAddr(pushAddr),
    .popReq(popReq), .popAddr(popAddr), .stackFull(stackFull),
    .underflow(underflow), .irqReq(irqReq), .irqAck(irqAck)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expFull();
    return model.size() == DP;
  endfunction

  function automatic logic [AW-1:0] expTop();
    return (model.size() > 0) ? model[model.size()-1] : '0;
  endfunction

  function automatic bit expAck(bit pu, bit po);
    return pend && !expFull() && !pu && !po;
  endfunction

  // one cycle: drive at negedge, check comb outputs, update model at posedge
  task automatic step(bit pu, bit po, bit iq, logic [AW-1:0] a, string sc);
    bit ack;
    pushReq = pu; popReq = po; irqReq = iq; pushAddr = a;
    #1;
    ack = expAck(pu, po);
    chk({sc, " R3 stackFull"}, AW'(stackFull), AW'(expFull()));
    chk({sc, " R7 irqAck"}, AW'(irqAck), AW'(ack));
    chk({sc, " R5 underflow"}, AW'(underflow), AW'(po && model.size() == 0));
    if (po) chk({sc, " R2 popAddr"}, popAddr, expTop());
    @(posedge clk);
    pend = ack ? 1'b0 : (pend || iq);
    if (ack) model.push_back(a);
    else if (pu && po) begin
      if (model.size() > 0) model[model.size()-1] = a;
      else model.push_back(a);
    end else if (pu) begin
      model.push_back(a);
      if (model.size() > DP) void'(model.pop_front());
    end else if (po && model.size() > 0) void'(model.pop_back());
    @(negedge clk);
    pushReq = 0; popReq = 0; irqReq = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    pend = 0;
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    // R1: reset state and pop on empty
    step(0, 0, 0, '0, "R1 idle");
    step(0, 1, 0, '0, "R1 empty pop");
    // R3/R4: fill, wrap, drain
    for (int i = 1; i <= 5; i++) step(1, 0, 0, AW'(16'h100 + i), "R4 fill");
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0, "R4 drain");
    // R6: replace on empty and non-empty
    step(1, 1, 0, 13'h0aa, "R6 empty pair");
    step(1, 0, 0, 13'h0bb, "R6 push");
    step(1, 1, 0, 13'h0cc, "R6 pair");
    step(0, 1, 0, '0, "R6 pop");
    step(0, 1, 0, '0, "R6 pop");
    // R9: interrupt held while full, released after a return
    for (int i = 0; i < 4; i++) step(1, 0, 0, AW'(16'h200 + i), "R9 fill");
    step(0, 0, 1, '0, "R9 request");
    step(0, 0, 0, 13'h1ff, "R9 held");
    step(1, 0, 0, 13'h210, "R9 call while full");
    step(0, 1, 0, '0, "R9 return");
    step(1, 0, 0, 13'h211, "R7 busy blocks ack");
    step(0, 1, 0, '0, "R9 return");
    step(0, 0, 1, 13'h1e0, "R8 ack merge");
    step(0, 0, 0, '0, "R8 no second ack");
    step(0, 1, 0, '0, "R8 pop irq addr");
    // R10: reset with full stack and pending interrupt
    for (int i = 0; i < 4; i++) step(1, 0, 0, AW'(16'h300 + i), "R10 fill");
    step(0, 0, 1, '0, "R10 pend");
    doReset();
    step(0, 0, 0, '0, "R10 after reset");
    step(0, 1, 0, '0, "R10 empty pop");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit pu = ($urandom % 3) == 0;
      bit po = ($urandom % 3) == 0;
      bit iq = ($urandom % 8) == 0;
      step(pu, po, iq, AW'($urandom), "R2 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule